// File: doc/BRIEF.md
# Frontbuffer Dirty Tracker with Rearm Timer

This block keeps a record of which display planes on the self-refresh pipe have framebuffer contents that changed since the panel last cached a frame. Rendering logic sends it an invalidate pulse when drawing into a plane begins, and a flush pulse when that drawing reaches memory. Each pulse carries a plane bitmask. Either kind of pulse, if it touches a plane of the pipe, makes the block ask the self-refresh controller to leave self-refresh.

Once a flush leaves no dirty planes and the controller is not active, the block starts a rearm timer of programmable length. When the timer expires, the block checks the dirty record again. If the record is still clean and the block is still enabled, it waits for the controller to report idle and then raises a one-cycle activate request. If idle does not arrive within a fixed number of cycles, the block drops the activation and sets a sticky error flag.

Top module: `fb_dirty_rearm`

## Requirements
- R1: Plane masks on invalidate and flush are ANDed with `pipe_mask` before any use. A pulse whose masked bits are all zero raises no exit request and leaves the dirty record unchanged.
- R2: An invalidate pulse with a nonzero masked mask ORs those bits into the dirty record. It also raises `exit_req` for one cycle, in the cycle after the clock edge that samples the pulse.
- R3: A flush pulse with a nonzero masked mask clears those bits from the dirty record. With the same timing as R2, it raises `exit_req`.
- R4: The rearm timer starts on a flush only when three conditions hold: the dirty record is empty after the flush, `ctrl_active` is low, and no timer is already pending. A second flush while a timer is pending does not restart it. With a delay of D cycles on `rearm_delay` and `ctrl_idle` high, `activate_req` is high in the cycle after the (D+2)-th clock edge counted from the edge that samples the flush.
- R5: When the timer expires and the dirty record is nonzero, including from an invalidate in the same cycle, the block drops the expiry. No activate request follows.
- R6: After a valid expiry, the block waits for `ctrl_idle`. If `ctrl_idle` stays low for IDLE_TMO clock edges, the block issues no activate request and sets `idle_err`. With D as in R4, this happens at edge D+1+IDLE_TMO counted from the flush edge.
- R7: While `enable` is low, any pending timer is cancelled. Invalidate and flush pulses are ignored: no exit request, and no change to the dirty record.
- R8: At the clock edge where `enable` is first seen high, the dirty record and `idle_err` are cleared. `idle_err` otherwise stays set until then.
- R9: `activate_req` is a single-cycle pulse and is issued only after `ctrl_idle` was sampled high while the block was enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable |
| pipe_mask | input | NPL | Planes that belong to the self-refresh pipe |
| inv_valid | input | 1 | Invalidate pulse |
| inv_mask | input | NPL | Planes being invalidated |
| flush_valid | input | 1 | Flush pulse |
| flush_mask | input | NPL | Planes being flushed |
| ctrl_active | input | 1 | Self-refresh controller is active |
| ctrl_idle | input | 1 | Self-refresh controller reports idle |
| rearm_delay | input | DW | Rearm delay in cycles |
| exit_req | output | 1 | Request to exit self-refresh |
| activate_req | output | 1 | Request to enter self-refresh |
| idle_err | output | 1 | Sticky flag: the wait for idle timed out |

## Verification
The bench builds the block with four planes and an idle timeout of 8 cycles. At run time it drives a rearm delay of 5 cycles. These values keep each expiry and each timeout within a few tens of cycles, so the bench can check the exact edge of every activation and every error. Short windows also make it easy to place an invalidate between the start of the timer and its expiry, and to send a second flush while a timer is pending.

// File: rtl/fb_dirty_rearm.sv
module fb_dirty_rearm #(
  parameter int NPL = 8,
  parameter int DW = 24,
  parameter int IDLE_TMO = 1024
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [NPL-1:0] pipe_mask,
  input  logic           inv_valid,
  input  logic [NPL-1:0] inv_mask,
  input  logic           flush_valid,
  input  logic [NPL-1:0] flush_mask,
  input  logic           ctrl_active,
  input  logic           ctrl_idle,
  input  logic [DW-1:0]  rearm_delay,
  output logic           exit_req,
  output logic           activate_req,
  output logic           idle_err
);
  localparam int TW = $clog2(IDLE_TMO + 1);

  typedef enum logic [1:0] {S_OFF, S_DLY, S_WAIT} st_t;

  st_t            st;
  logic [NPL-1:0] busy;
  logic           en_q;
  logic [DW-1:0]  dcnt;
  logic [TW-1:0]  tcnt;

  logic [NPL-1:0] inv_m, fl_m, busy_nx;
  logic           start, en_rise;

  assign inv_m   = (enable && inv_valid)   ? (inv_mask & pipe_mask)   : '0;
  assign fl_m    = (enable && flush_valid) ? (flush_mask & pipe_mask) : '0;
  assign busy_nx = (busy | inv_m) & ~fl_m;
  assign en_rise = enable && !en_q;
  assign start   = enable && flush_valid && !ctrl_active && (busy_nx == '0) && (st == S_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_OFF;
      busy         <= '0;
      en_q         <= 1'b0;
      dcnt         <= '0;
      tcnt         <= '0;
      exit_req     <= 1'b0;
      activate_req <= 1'b0;
      idle_err     <= 1'b0;
    end else begin
      en_q         <= enable;
      exit_req     <= (|inv_m) || (|fl_m);
      activate_req <= 1'b0;
      if (en_rise) begin
        busy     <= '0;
        idle_err <= 1'b0;
        st       <= S_OFF;
      end else if (!enable) begin
        st <= S_OFF;
      end else begin
        busy <= busy_nx;
        case (st)
          S_OFF: if (start) begin
            st   <= S_DLY;
            dcnt <= rearm_delay;
          end
          S_DLY: begin
            if (dcnt != '0) dcnt <= dcnt - 1'b1;
            else if (busy_nx == '0) begin
              st   <= S_WAIT;
              tcnt <= '0;
            end else st <= S_OFF;
          end
          S_WAIT: begin
            if (ctrl_idle) begin
              activate_req <= 1'b1;
              st           <= S_OFF;
            end else if (tcnt == TW'(IDLE_TMO - 1)) begin
              idle_err <= 1'b1;
              st       <= S_OFF;
            end else tcnt <= tcnt + 1'b1;
          end
          default: st <= S_OFF;
        endcase
      end
    end
  end

  a_r9_act_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    activate_req |=> !activate_req);

  a_r9_act_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    activate_req |-> ($past(ctrl_idle) && $past(enable)));

  a_r7_no_exit_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |-> $past(enable));

  a_r6_err_no_act: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_err) |-> !activate_req);

  a_r8_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |=> !idle_err);
endmodule

// File: tb/sim_fb_dirty_rearm.sv
module sim_fb_dirty_rearm;
  logic clk = 0, rst_n = 0, enable = 0;
  logic [3:0] pipe_mask = 4'hF, inv_mask = 0, flush_mask = 0;
  logic inv_valid = 0, flush_valid = 0, ctrl_active = 1, ctrl_idle = 1;
  logic [7:0] rearm_delay = 8'd5;
  logic exit_req, activate_req, idle_err;
  int tests = 0, fails = 0;
  localparam int D = 5, TMO = 8;

  always #4 clk = ~clk;

  fb_dirty_rearm #(.NPL(4), .DW(8), .IDLE_TMO(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pipe_mask(pipe_mask),
    .inv_valid(inv_valid), .inv_mask(inv_mask), .flush_valid(flush_valid),
    .flush_mask(flush_mask), .ctrl_active(ctrl_active), .ctrl_idle(ctrl_idle),
    .rearm_delay(rearm_delay), .exit_req(exit_req), .activate_req(activate_req),
    .idle_err(idle_err));

  // {pipe, inv_v, inv_m, fl_v, fl_m, exp_exit}
  localparam logic [14:0] VEC [8] = '{
    {4'hF,1'b1,4'h1,1'b0,4'h0,1'b1},
    {4'h3,1'b1,4'hC,1'b0,4'h0,1'b0},
    {4'h3,1'b1,4'h2,1'b0,4'h0,1'b1},
    {4'hF,1'b0,4'hF,1'b0,4'h0,1'b0},
    {4'hF,1'b0,4'h0,1'b1,4'h4,1'b1},
    {4'hC,1'b0,4'h0,1'b1,4'h3,1'b0},
    {4'h0,1'b1,4'hF,1'b1,4'hF,1'b0},
    {4'h6,1'b1,4'h8,1'b1,4'h4,1'b1}};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input logic iv, input logic [3:0] im, input logic fv,
                       input logic [3:0] fm, output logic ex);
    inv_valid = iv; inv_mask = im; flush_valid = fv; flush_mask = fm;
    tick();
    ex = exit_req;
    inv_valid = 0; inv_mask = 0; flush_valid = 0; flush_mask = 0;
  endtask

  task automatic watch(input int w, output int ka, output int ke);
    ka = 0; ke = 0;
    for (int k = 1; k <= w; k++) begin
      tick();
      if (activate_req && ka == 0) ka = k;
      if (idle_err && ke == 0) ke = k;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++; tests++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic ex;
    int ka, ke;
    @(negedge clk); tick(); tick();
    check(!exit_req && !activate_req && !idle_err, "reset", {exit_req, activate_req, idle_err}, 0);
    rst_n = 1; enable = 1; tick();

    for (int i = 0; i < 8; i++) begin
      pipe_mask = VEC[i][14:11];
      pulse(VEC[i][10], VEC[i][9:6], VEC[i][5], VEC[i][4:1], ex);
      check(ex == VEC[i][0], $sformatf("R1 R2 R3 vector %0d exit", i), ex, VEC[i][0]);
    end
    pipe_mask = 4'hF;
    pulse(0, 0, 1, 4'hF, ex); tick();

    ctrl_active = 0;
    pulse(0, 0, 1, 0, ex);
    watch(12, ka, ke);
    check(ka == D + 2, "R4 activation edge", ka, D + 2);

    pulse(0, 0, 1, 0, ex);
    watch(2, ka, ke);
    pulse(0, 0, 1, 0, ex);
    watch(10, ka, ke);
    check(ka == D + 2 - 3, "R4 pending timer not restarted", ka, D - 1);

    pulse(1, 4'h1, 0, 0, ex);
    check(ex, "R2 invalidate exit", ex, 1);
    pulse(0, 0, 1, 4'h2, ex);
    check(ex, "R3 flush exit", ex, 1);
    watch(12, ka, ke);
    check(ka == 0, "R4 no timer while busy", ka, 0);
    pulse(0, 0, 1, 4'h1, ex);
    watch(12, ka, ke);
    check(ka == D + 2, "R3 flush clears busy then rearm", ka, D + 2);

    ctrl_active = 1;
    pulse(0, 0, 1, 0, ex);
    watch(12, ka, ke);
    check(ka == 0, "R4 no timer while controller active", ka, 0);
    ctrl_active = 0;

    pulse(0, 0, 1, 0, ex);
    watch(3, ka, ke);
    pulse(1, 4'h4, 0, 0, ex);
    watch(12, ka, ke);
    check(ka == 0, "R5 racing invalidate drops expiry", ka, 0);
    pulse(0, 0, 1, 4'h4, ex);
    watch(12, ka, ke);
    check(ka == D + 2, "R5 recovery after flush", ka, D + 2);

    ctrl_idle = 0;
    pulse(0, 0, 1, 0, ex);
    watch(20, ka, ke);
    check(ke == D + 1 + TMO, "R6 idle timeout error edge", ke, D + 1 + TMO);
    check(ka == 0, "R6 no activation on timeout", ka, 0);
    ctrl_idle = 1;
    pulse(0, 0, 1, 0, ex);
    watch(12, ka, ke);
    check(idle_err == 1, "R8 error sticky", idle_err, 1);
    enable = 0; tick(); enable = 1; tick();
    check(idle_err == 0, "R8 error cleared on enable", idle_err, 0);

    pulse(0, 0, 1, 0, ex);
    watch(2, ka, ke);
    enable = 0;
    watch(12, ka, ke);
    check(ka == 0, "R7 disable cancels timer", ka, 0);
    pulse(1, 4'h1, 0, 0, ex);
    check(!ex, "R7 invalidate ignored while off", ex, 0);
    pulse(0, 0, 1, 4'h1, ex);
    check(!ex, "R7 flush ignored while off", ex, 0);
    enable = 1; tick();
    pulse(0, 0, 1, 0, ex);
    watch(12, ka, ke);
    check(ka == D + 2, "R7 invalidate while off left busy clean", ka, D + 2);

    pulse(1, 4'h2, 0, 0, ex);
    enable = 0; tick(); enable = 1; tick();
    pulse(0, 0, 1, 0, ex);
    watch(12, ka, ke);
    check(ka == D + 2, "R8 enable clears busy", ka, D + 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule